// File: doc/BRIEF.md
# Sleep-State and Oscillator Warm-up Controller

This block decides which clocks of a small core run. In the running state the CPU clock enable, the peripheral clock enable and the oscillator enable are all high. A light sleep command drops only the CPU clock enable, so the timer and other peripherals keep counting. Any pending interrupt brings the CPU clock back on the next cycle, with no delay.

A deep sleep command also drops the oscillator enable. Only the port wake line can end deep sleep. Because no oscillator clock runs in deep sleep, the port wake line raises the oscillator enable directly, without passing through a register. A synchronizer then carries the line into the oscillator clock domain, and the controller starts an oscillator warm-up.

The same warm-up follows power-on reset. During warm-up the core is held: ready is low and the CPU and peripheral clocks are gated. The count lasts a fixed number of oscillator cycles, 512 by default. For example, 512 cycles at 4 MHz is 0.128 ms. Sleep commands that arrive during warm-up are ignored.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, cpu_clk_en=0, periph_clk_en=0, core_ready=0 and osc_en=1. core_ready rises after exactly WARM_CYCLES (512) rising clock edges following reset release.
- R2: Throughout a warm-up, cpu_clk_en, periph_clk_en and core_ready are 0 and osc_en is 1. core_ready goes high on the edge after the internal counter reaches WARM_CYCLES-1.
- R3: In the running state, a high halt_req (with stop_req low) at a clock edge gives, after that edge, cpu_clk_en=0 with periph_clk_en=1, osc_en=1 and core_ready=1. This light sleep state persists while irq_pending is low.
- R4: In light sleep, a high irq_pending at a clock edge restores cpu_clk_en=1 after that edge, with no warm-up.
- R5: In the running state, a high stop_req at a clock edge gives, after that edge, cpu_clk_en=0, periph_clk_en=0, core_ready=0 and osc_en=0. stop_req takes priority when halt_req is high at the same time.
- R6: In deep sleep, irq_pending and halt_req have no effect: all four outputs stay 0 while port_wake is low.
- R7: In deep sleep, osc_en follows port_wake without any clock edge. The wake passes through SYNC_STAGES (2) flops and one state edge, and then a warm-up starts. core_ready therefore rises SYNC_STAGES+1+WARM_CYCLES (515) edges after port_wake rises.
- R8: halt_req and stop_req arriving during a warm-up are ignored. The warm-up still ends after WARM_CYCLES edges, and osc_en stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_req | input | 1 | Light sleep command, one cycle |
| stop_req | input | 1 | Deep sleep command, one cycle |
| irq_pending | input | 1 | Any interrupt pending |
| port_wake | input | 1 | Asynchronous port interrupt wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral (timer) clock enable |
| core_ready | output | 1 | Warm-up complete, core released |

## Verification
The assertions check on every cycle:
- the output gating during warm-up;
- that warm-up finishes only once an independent cycle count reaches its last value;
- that warm-up is never interrupted;
- the one-cycle entry into, and exit from, light sleep;
- the entry into deep sleep and its immunity to interrupts.

Only the bench scenarios can show the whole-path latencies. These are the 512-edge delay after reset and the 515-edge delay from a port wake to ready. The bench also shows that commands issued in the middle of a warm-up leave its length unchanged, and that a reset during light sleep restarts the warm-up.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [1:0] {
    PS_WARM = 2'd0,
    PS_RUN  = 2'd1,
    PS_HALT = 2'd2,
    PS_STOP = 2'd3
  } pwr_state_t;

  // Next-state rule: deep sleep wins over light sleep; warm-up is not interruptible.
  function automatic pwr_state_t pwr_next(input pwr_state_t cur,
                                          input logic halt,
                                          input logic stop,
                                          input logic irq,
                                          input logic wake,
                                          input logic warm_done);
    pwr_state_t nxt;
    nxt = cur;
    case (cur)
      PS_WARM: if (warm_done) nxt = PS_RUN;
      PS_RUN: begin
        if (stop)      nxt = PS_STOP;
        else if (halt) nxt = PS_HALT;
      end
      PS_HALT: if (irq) nxt = PS_RUN;
      PS_STOP: if (wake) nxt = PS_WARM;
      default: nxt = PS_WARM;
    endcase
    return nxt;
  endfunction

  function automatic logic cpu_on(input pwr_state_t s);
    return s == PS_RUN;
  endfunction

  function automatic logic periph_on(input pwr_state_t s);
    return (s == PS_RUN) || (s == PS_HALT);
  endfunction

  // Edges from a port wake rising to ready rising.
  function automatic int wake_latency(input int sync_stages, input int warm_cycles);
    return sync_stages + 1 + warm_cycles;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = async_in;
    end else begin : g_next
      assign d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_warm_counter.sv
module pwr_warm_counter #(
  parameter int CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (run && !done)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int WARM_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic halt_req,
  input  logic stop_req,
  input  logic irq_pending,
  input  logic port_wake,
  output logic cpu_clk_en,
  output logic osc_en,
  output logic periph_clk_en,
  output logic core_ready
);

  pwr_state_t state_q, state_d;
  logic       wake_sync;
  logic       warm_active;
  logic       warm_done;
  logic       warm_clear;

  pwr_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .async_in (port_wake),
    .sync_out (wake_sync)
  );

  pwr_warm_counter #(.CYCLES(WARM_CYCLES)) u_warm (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .clear (warm_clear),
    .run   (warm_active),
    .done  (warm_done)
  );

  assign warm_active = (state_q == PS_WARM);
  assign state_d     = pwr_next(state_q, halt_req, stop_req, irq_pending,
                                wake_sync, warm_done);
  assign warm_clear  = (state_d == PS_WARM) && !warm_active;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) state_q <= PS_WARM;
    else        state_q <= state_d;
  end

  assign cpu_clk_en    = cpu_on(state_q);
  assign periph_clk_en = periph_on(state_q);
  assign core_ready    = periph_on(state_q);
  // The port wake restarts the oscillator without needing a clock edge.
  assign osc_en        = (state_q != PS_STOP) || port_wake;

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int WARM_CYCLES = 512
) (
  input logic clk_osc,
  input logic rst_n,
  input logic halt_req,
  input logic stop_req,
  input logic irq_pending,
  input logic port_wake,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic periph_clk_en,
  input logic core_ready,
  input logic warm_active,
  input logic warm_done
);

  localparam int CW = $clog2(WARM_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (!warm_active) cyc_q <= '0;
    else if (cyc_q != LAST) cyc_q <= cyc_q + 1'b1;
  end

  p_warm_len_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    warm_done |-> (cyc_q == LAST));

  p_warm_gate_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    warm_active |-> (!cpu_clk_en && !periph_clk_en && !core_ready && osc_en));

  p_warm_hold_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (warm_active && !warm_done) |=> warm_active);

  p_halt_enter_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (cpu_clk_en && halt_req && !stop_req) |=> (!cpu_clk_en && periph_clk_en && core_ready));

  p_halt_wake_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!cpu_clk_en && periph_clk_en && irq_pending) |=> cpu_clk_en);

  p_stop_enter_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (cpu_clk_en && stop_req) |=> (!cpu_clk_en && !periph_clk_en && !core_ready));

  p_stop_irq_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!periph_clk_en && !warm_active && irq_pending) |=> (!core_ready && !cpu_clk_en));

  p_stop_osc_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!periph_clk_en && !warm_active && port_wake) |-> osc_en);

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.WARM_CYCLES(WARM_CYCLES)) chk_i (
  .clk_osc       (clk_osc),
  .rst_n         (rst_n),
  .halt_req      (halt_req),
  .stop_req      (stop_req),
  .irq_pending   (irq_pending),
  .port_wake     (port_wake),
  .cpu_clk_en    (cpu_clk_en),
  .osc_en        (osc_en),
  .periph_clk_en (periph_clk_en),
  .core_ready    (core_ready),
  .warm_active   (warm_active),
  .warm_done     (warm_done)
);

// File: tb/pwr_sleep_ctrl_tb_top.sv
module pwr_sleep_ctrl_tb_top;

  localparam int WARM = 512;
  localparam int SYNC = 2;
  localparam int WAKE_LAT = SYNC + 1 + WARM;

  logic clk_osc = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, stop_req = 1'b0, irq_pending = 1'b0, port_wake = 1'b0;
  logic cpu_clk_en, osc_en, periph_clk_en, core_ready;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk_osc = ~clk_osc;

  pwr_sleep_ctrl #(.WARM_CYCLES(WARM), .SYNC_STAGES(SYNC)) dut_i (
    .clk_osc(clk_osc), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pending(irq_pending), .port_wake(port_wake), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .periph_clk_en(periph_clk_en), .core_ready(core_ready)
  );

  // Row: {req[3:0], halt, stop, irq, port, cpu, osc, per, rdy}
  localparam int NROWS = 10;
  localparam logic [11:0] VEC [NROWS] = '{
    {4'd3, 4'b0000, 4'b1111},  // R3 idle, stays running
    {4'd3, 4'b1000, 4'b0111},  // R3 enter light sleep
    {4'd3, 4'b0000, 4'b0111},  // R3 light sleep persists
    {4'd4, 4'b0010, 4'b1111},  // R4 interrupt wakes at once
    {4'd5, 4'b1100, 4'b0000},  // R5 both commands: deep sleep wins
    {4'd6, 4'b0010, 4'b0000},  // R6 interrupt ignored
    {4'd6, 4'b1000, 4'b0000},  // R6 halt ignored
    {4'd7, 4'b0001, 4'b0100},  // R7 wake flop 1
    {4'd7, 4'b0001, 4'b0100},  // R7 wake flop 2
    {4'd7, 4'b0001, 4'b0100}   // R7 enters warm-up
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (cpu,osc,per,rdy)", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {cpu_clk_en, osc_en, periph_clk_en, core_ready};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Counts edges until core_ready rises; flags gating violations during the wait.
  task automatic wait_ready(input int limit, output int edges, output int bad);
    edges = 0;
    bad = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk_osc);
      #1;
      if (core_ready) begin
        edges = k;
        break;
      end
      if (cpu_clk_en || periph_clk_en || !osc_en) bad++;
    end
  endtask

  initial begin
    #(20000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int edges, bad;
    logic [3:0] r;
    // R1 reset state
    #23;
    check("R1", outs(), 4'b0100);
    @(negedge clk_osc);
    rst_n = 1'b1;
    wait_ready(WARM + 10, edges, bad);
    check_int("R1", edges, WARM);
    check_int("R2", bad, 0);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk_osc);
      {halt_req, stop_req, irq_pending, port_wake} = VEC[i][7:4];
      if (i == 7) begin
        #1;
        checks++;
        if (osc_en !== 1'b1) begin
          failures++;
          $display("FAIL R7 actual=%b expected=1 (osc_en before edge)", osc_en);
        end
      end
      @(posedge clk_osc);
      #1;
      r = VEC[i][11:8];
      check($sformatf("R%0d", r), outs(), VEC[i][3:0]);
    end
    @(negedge clk_osc);
    {halt_req, stop_req, irq_pending} = 3'b000;

    // Rest of warm-up with commands thrown in (R8)
    edges = 0;
    bad = 0;
    for (int k = 1; k <= WARM + 10; k++) begin
      @(posedge clk_osc);
      #1;
      if (core_ready) begin
        edges = k;
        break;
      end
      if (cpu_clk_en || periph_clk_en || !osc_en) bad++;
      if (k == 50) port_wake = 1'b0;
      if (k == 100) begin
        halt_req = 1'b1;
        stop_req = 1'b1;
      end
      if (k == 101) begin
        halt_req = 1'b0;
        stop_req = 1'b0;
      end
    end
    check_int("R7", edges + 3, WAKE_LAT);
    check_int("R8", bad, 0);
    check("R8", outs(), 4'b1111);

    // Light sleep, then a reset restarts the warm-up (R1)
    @(negedge clk_osc);
    halt_req = 1'b1;
    @(posedge clk_osc);
    #1;
    check("R3", outs(), 4'b0111);
    @(negedge clk_osc);
    halt_req = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", outs(), 4'b0100);
    @(negedge clk_osc);
    rst_n = 1'b1;
    wait_ready(WARM + 10, edges, bad);
    check_int("R1", edges, WARM);
    check_int("R2", bad, 0);

    // Deep sleep held with no wake: irq stays ignored for many cycles (R6)
    @(negedge clk_osc);
    stop_req = 1'b1;
    @(negedge clk_osc);
    stop_req = 1'b0;
    irq_pending = 1'b1;
    repeat (20) @(posedge clk_osc);
    #1;
    check("R6", outs(), 4'b0000);
    irq_pending = 1'b0;
    report();
  end

endmodule